// File: doc/BRIEF.md
# Self-Invalidating Lease Cache

This block is a small direct-mapped cache for global shared data, placed at a site that is not the data's home. A line is kept only for a limited lifetime after it arrives. Each entry carries its own down-counter. The counter is loaded when the line is filled and counts down by one every clock. When the count runs out, the entry drops itself. No invalidation traffic from the home site is ever needed. Writes never go through this cache.

The processor side issues single-word reads, and each read carries the lifetime it would like. A miss sends a whole-line fetch to the home site. The home answers with the full line and the lifetime it grants. Only one miss may be in flight at a time. A renewal request can be forwarded to the home site while a line is still live. A grant that comes back for a live line reloads that line's counter. Whenever a line leaves the cache, because it expired or because a new fill replaced it, the block pulses a notice carrying the line address. Upper-level caches at the same site use this notice to drop their copies.

Top module: `lease_cache`

## Requirements
- R1: After reset, rd_ready is 1 and rd_resp_valid, fetch_valid, inval_valid and renew_req_valid are 0.
- R2: A read that is accepted (rd_valid and rd_ready both high) to a line not held live causes a one-cycle fetch_valid pulse in the next cycle. The pulse carries fetch_line = rd_addr[15:2] and fetch_lease = rd_lease.
- R3: A fill_valid that arrives while a miss is waiting stores all four words. Word k of the line is fill_data[32k+31:32k]. The counter is loaded with fill_lease. rd_resp_data returns the requested word two cycles after the fill cycle. A fill_valid that arrives with no miss waiting is ignored.
- R4: A read accepted to a live line returns the addressed word on rd_resp_data, with rd_resp_valid high, two cycles after acceptance. It raises no fetch.
- R5: A line filled with lifetime L hits for reads accepted in the L cycles after the fill edge. A read in the following cycle, when the counter has reached zero, is a miss even though the tag still matches. A lifetime of 0 gives no hits at all.
- R6: A line whose counter has reached zero is removed, with one inval_valid pulse carrying inval_line = {tag, index}. At most one notice is issued per cycle. When several lines wait, the lowest index goes first.
- R7: A fill into an index that holds a valid line emits the notice for the displaced line in the cycle after the fill. This notice takes precedence over any waiting expiry.
- R8: A renew_valid whose renew_line is live produces renew_req_valid with the same line in the next cycle. A renew_valid for a line that is not live produces nothing.
- R9: A grant_valid whose grant_line is live reloads that line's counter with grant_lease. A grant for a line that is absent or has reached zero is ignored.
- R10: At most one miss is outstanding. rd_ready stays low from the miss until the fill cycle, and a read held during that time is accepted after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 16 | Word address of the read |
| rd_lease | input | 16 | Lifetime requested with the read |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | 32 | Read data word |
| fetch_valid | output | 1 | Line fetch request to home site |
| fetch_line | output | 14 | Line address of fetch |
| fetch_lease | output | 16 | Lifetime requested from home |
| fill_valid | input | 1 | Line fill from home site |
| fill_data | input | 128 | Whole line, word k at bits 32k+31:32k |
| fill_lease | input | 16 | Lifetime granted with the fill |
| renew_valid | input | 1 | Local request to renew a line |
| renew_line | input | 14 | Line address to renew |
| renew_req_valid | output | 1 | Renewal request to home site |
| renew_req_line | output | 14 | Line address of renewal |
| grant_valid | input | 1 | Renewal grant from home site |
| grant_line | input | 14 | Line address of grant |
| grant_lease | input | 16 | New lifetime for the granted line |
| inval_valid | output | 1 | Invalidate notice to upper caches |
| inval_line | output | 14 | Line address being dropped |

## Verification
A counter that is off by one shows at the ports in two ways. A read in the last live cycle or the first expired cycle gives the wrong hit or miss, so fetch_valid is wrong one cycle later. The inval_valid pulse also appears a cycle early or late. A corrupted tag or valid bit shows up as a spurious or missing fetch on the next read to that index, and as a wrong inval_line when the line leaves. A wrong order in the removal arbiter shows as swapped notice addresses on consecutive cycles. The bench's reference model compares every one of these outputs in every cycle, so a fault shows up within one to two cycles of the event that exposes it.

// File: rtl/lease_cache_pkg.sv
package lease_cache_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} miss_st_t;
endpackage

// File: rtl/lease_line_ram.sv
module lease_line_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int W     = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lease_pick.sv
module lease_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/lease_tracker.sv
module lease_tracker #(
  parameter int LINES   = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 10,
  parameter int LEASE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            look_idx,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        look_live,
  input  logic [IDX_W-1:0]            ren_idx,
  input  logic [TAG_W-1:0]            ren_tag,
  output logic                        ren_live,
  input  logic                        fill_en,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [LEASE_W-1:0]          fill_lease,
  input  logic                        grant_en,
  input  logic [IDX_W-1:0]            grant_idx,
  input  logic [TAG_W-1:0]            grant_tag,
  input  logic [LEASE_W-1:0]          grant_lease,
  input  logic                        retire_en,
  input  logic [IDX_W-1:0]            retire_idx,
  output logic [LINES-1:0]            valid_o,
  output logic [LINES-1:0][TAG_W-1:0] tag_o,
  output logic [LINES-1:0]            expired_o
);
  logic [LINES-1:0] nz;
  logic             grant_live;

  assign look_live  = valid_o[look_idx] && (tag_o[look_idx] == look_tag) && nz[look_idx];
  assign ren_live   = valid_o[ren_idx] && (tag_o[ren_idx] == ren_tag) && nz[ren_idx];
  assign grant_live = grant_en && valid_o[grant_idx] &&
                      (tag_o[grant_idx] == grant_tag) && nz[grant_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic               v_q;
    logic [TAG_W-1:0]   t_q;
    logic [LEASE_W-1:0] c_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        t_q <= '0;
        c_q <= '0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        v_q <= 1'b1;
        t_q <= fill_tag;
        c_q <= fill_lease;
      end else if (retire_en && retire_idx == IDX_W'(i)) begin
        v_q <= 1'b0;
      end else if (grant_live && grant_idx == IDX_W'(i)) begin
        c_q <= grant_lease;
      end else if (v_q && c_q != '0) begin
        c_q <= c_q - 1'b1;
      end
    end

    assign valid_o[i]   = v_q;
    assign tag_o[i]     = t_q;
    assign nz[i]        = (c_q != '0);
    assign expired_o[i] = v_q && (c_q == '0);
  end
endmodule

// File: rtl/lease_cache.sv
module lease_cache
  import lease_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int LINES   = 16,
  parameter int LEASE_W = 16,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int TAG_W   = LADDR_W - IDX_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_valid,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [LEASE_W-1:0] rd_lease,
  output logic               rd_ready,
  output logic               rd_resp_valid,
  output logic [DATA_W-1:0]  rd_resp_data,
  output logic               fetch_valid,
  output logic [LADDR_W-1:0] fetch_line,
  output logic [LEASE_W-1:0] fetch_lease,
  input  logic               fill_valid,
  input  logic [LINE_W-1:0]  fill_data,
  input  logic [LEASE_W-1:0] fill_lease,
  input  logic               renew_valid,
  input  logic [LADDR_W-1:0] renew_line,
  output logic               renew_req_valid,
  output logic [LADDR_W-1:0] renew_req_line,
  input  logic               grant_valid,
  input  logic [LADDR_W-1:0] grant_line,
  input  logic [LEASE_W-1:0] grant_lease,
  output logic               inval_valid,
  output logic [LADDR_W-1:0] inval_line
);
  miss_st_t st;

  logic [OFF_W-1:0] rq_off;
  logic [IDX_W-1:0] rq_idx;
  logic [TAG_W-1:0] rq_tag;
  assign rq_off = rd_addr[OFF_W-1:0];
  assign rq_idx = rd_addr[OFF_W +: IDX_W];
  assign rq_tag = rd_addr[ADDR_W-1 -: TAG_W];

  logic [OFF_W-1:0] p_off;
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag;

  logic                        look_live, ren_live;
  logic [LINES-1:0]            valid_v, exp_v;
  logic [LINES-1:0][TAG_W-1:0] tag_v;
  logic                        pick_any;
  logic [IDX_W-1:0]            pick_idx;

  logic acc, hit, miss, fill_go, evict, retire_en;
  assign rd_ready  = (st == ST_IDLE);
  assign acc       = rd_valid && rd_ready;
  assign hit       = acc && look_live;
  assign miss      = acc && !look_live;
  assign fill_go   = fill_valid && (st == ST_WAIT);
  assign evict     = fill_go && valid_v[p_idx];
  assign retire_en = pick_any && !evict;

  lease_tracker #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LEASE_W(LEASE_W)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .look_idx    (rq_idx),
    .look_tag    (rq_tag),
    .look_live   (look_live),
    .ren_idx     (renew_line[IDX_W-1:0]),
    .ren_tag     (renew_line[LADDR_W-1:IDX_W]),
    .ren_live    (ren_live),
    .fill_en     (fill_go),
    .fill_idx    (p_idx),
    .fill_tag    (p_tag),
    .fill_lease  (fill_lease),
    .grant_en    (grant_valid),
    .grant_idx   (grant_line[IDX_W-1:0]),
    .grant_tag   (grant_line[LADDR_W-1:IDX_W]),
    .grant_lease (grant_lease),
    .retire_en   (retire_en),
    .retire_idx  (pick_idx),
    .valid_o     (valid_v),
    .tag_o       (tag_v),
    .expired_o   (exp_v)
  );

  lease_pick #(.N(LINES), .IW(IDX_W)) u_pick (
    .req (exp_v),
    .any (pick_any),
    .idx (pick_idx)
  );

  logic [LINE_W-1:0] ram_q;
  lease_line_ram #(.DEPTH(LINES), .AW(IDX_W), .W(LINE_W)) u_ram (
    .clk   (clk),
    .we    (fill_go),
    .waddr (p_idx),
    .wdata (fill_data),
    .raddr (rq_idx),
    .rdata (ram_q)
  );

  // miss control and network-side requests
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      p_off       <= '0;
      p_idx       <= '0;
      p_tag       <= '0;
      fetch_valid <= 1'b0;
      fetch_line  <= '0;
      fetch_lease <= '0;
    end else begin
      fetch_valid <= miss;
      if (miss) begin
        st          <= ST_WAIT;
        p_off       <= rq_off;
        p_idx       <= rq_idx;
        p_tag       <= rq_tag;
        fetch_line  <= rd_addr[ADDR_W-1:OFF_W];
        fetch_lease <= rd_lease;
      end else if (fill_go) begin
        st <= ST_IDLE;
      end
    end
  end

  // two-stage response path: stage 1 holds the line, stage 2 the word
  logic              s1_v, s1_fill;
  logic [OFF_W-1:0]  s1_off;
  logic [LINE_W-1:0] fill_buf;
  logic [LINE_W-1:0] s1_line;
  assign s1_line = s1_fill ? fill_buf : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v          <= 1'b0;
      s1_fill       <= 1'b0;
      s1_off        <= '0;
      fill_buf      <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      s1_v    <= hit || fill_go;
      s1_fill <= fill_go;
      s1_off  <= fill_go ? p_off : rq_off;
      if (fill_go) fill_buf <= fill_data;
      rd_resp_valid <= s1_v;
      if (s1_v) rd_resp_data <= s1_line[s1_off*DATA_W +: DATA_W];
    end
  end

  // renewal forwarding and removal notices
  always_ff @(posedge clk) begin
    if (rst) begin
      renew_req_valid <= 1'b0;
      renew_req_line  <= '0;
      inval_valid     <= 1'b0;
      inval_line      <= '0;
    end else begin
      renew_req_valid <= renew_valid && ren_live;
      if (renew_valid) renew_req_line <= renew_line;
      inval_valid <= evict || pick_any;
      if (evict)         inval_line <= {tag_v[p_idx], p_idx};
      else if (pick_any) inval_line <= {tag_v[pick_idx], pick_idx};
    end
  end
endmodule

// File: rtl/lease_cache_chk.sv
module lease_cache_chk (
  input logic clk,
  input logic rst,
  input logic rd_valid,
  input logic rd_ready,
  input logic rd_resp_valid,
  input logic fetch_valid,
  input logic fill_valid,
  input logic renew_valid,
  input logic renew_req_valid
);
  a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  a_r2_fetch_follows_accept: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> $past(rd_valid && rd_ready));

  a_r10_stall_while_waiting: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> !rd_ready);

  a_r3_fill_releases: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !rd_ready) |=> rd_ready);

  a_r8_renew_has_cause: assert property (@(posedge clk) disable iff (rst)
    renew_req_valid |-> $past(renew_valid));

  a_r4_resp_has_cause: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid |-> ($past(rd_valid && rd_ready, 2) || $past(fill_valid && !rd_ready, 2)));
endmodule

bind lease_cache lease_cache_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .rd_valid        (rd_valid),
  .rd_ready        (rd_ready),
  .rd_resp_valid   (rd_resp_valid),
  .fetch_valid     (fetch_valid),
  .fill_valid      (fill_valid),
  .renew_valid     (renew_valid),
  .renew_req_valid (renew_req_valid)
);

// File: tb/lease_cache_bench.sv
module lease_cache_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rd_valid = 1'b0;
  logic [15:0]  rd_addr = '0;
  logic [15:0]  rd_lease = '0;
  logic         rd_ready, rd_resp_valid;
  logic [31:0]  rd_resp_data;
  logic         fetch_valid;
  logic [13:0]  fetch_line;
  logic [15:0]  fetch_lease;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_data = '0;
  logic [15:0]  fill_lease = '0;
  logic         renew_valid = 1'b0;
  logic [13:0]  renew_line = '0;
  logic         renew_req_valid;
  logic [13:0]  renew_req_line;
  logic         grant_valid = 1'b0;
  logic [13:0]  grant_line = '0;
  logic [15:0]  grant_lease = '0;
  logic         inval_valid;
  logic [13:0]  inval_line;

  always #4 clk = ~clk;

  lease_cache u_lease_cache (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int          m_valid [16];
  int          m_tag   [16];
  int          m_cnt   [16];
  int          m_grant [16];
  logic [31:0] m_mem   [16][4];
  bit          m_wait;
  int          m_pidx, m_ptag, m_poff;
  bit          p1_v;
  logic [31:0] p1_d;
  string       p1_tag;
  bit          e_ready, e_rv, e_fv, e_iv, e_nv;
  logic [31:0] e_rd;
  logic [13:0] e_fl, e_il, e_nl;
  logic [15:0] e_fls;
  string       e_rtag, e_ftag, e_itag;
  bit          cmp_on = 0;

  function automatic bit m_live(int i, int t);
    return m_valid[i] != 0 && m_tag[i] == t && m_cnt[i] != 0;
  endfunction

  always @(posedge clk) begin
    cmp_on <= 1;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        m_valid[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; m_grant[i] = 0;
      end
      m_wait = 0; p1_v = 0; e_rv = 0; e_fv = 0; e_iv = 0; e_nv = 0; e_ready = 1;
    end else begin
      int  ri, rt, ro, gi, gt, nidx, ret;
      bit  acc, fil;
      ri = int'(rd_addr[5:2]); rt = int'(rd_addr[15:6]); ro = int'(rd_addr[1:0]);
      gi = int'(grant_line[3:0]); gt = int'(grant_line[13:4]);
      e_rv = p1_v; e_rd = p1_d; e_rtag = p1_tag;
      p1_v = 0;
      e_fv = 0; e_iv = 0; e_nv = 0;
      acc = rd_valid && !m_wait;
      fil = fill_valid && m_wait;
      if (acc) begin
        if (m_live(ri, rt)) begin
          p1_v = 1; p1_d = m_mem[ri][ro]; p1_tag = "R4";
        end else begin
          e_fv = 1; e_fl = rd_addr[15:2]; e_fls = rd_lease;
          e_ftag = (m_valid[ri] != 0 && m_tag[ri] == rt) ? "R5" : "R2";
          m_wait = 1; m_pidx = ri; m_ptag = rt; m_poff = ro;
        end
      end
      if (fil) begin
        p1_v = 1; p1_d = fill_data[m_poff*32 +: 32]; p1_tag = "R3";
        m_wait = 0;
      end
      if (renew_valid && m_live(int'(renew_line[3:0]), int'(renew_line[13:4]))) begin
        e_nv = 1; e_nl = renew_line;
      end
      ret = -1;
      if (fil && m_valid[m_pidx] != 0) begin
        e_iv = 1; e_il = 14'((m_tag[m_pidx] << 4) | m_pidx); e_itag = "R7";
      end else begin
        nidx = -1;
        for (int i = 15; i >= 0; i--) if (m_valid[i] != 0 && m_cnt[i] == 0) nidx = i;
        if (nidx >= 0) begin
          e_iv = 1; e_il = 14'((m_tag[nidx] << 4) | nidx);
          e_itag = (m_grant[nidx] != 0) ? "R9" : "R6";
          ret = nidx;
        end
      end
      for (int i = 0; i < 16; i++) begin
        if (fil && i == m_pidx) begin
          m_valid[i] = 1; m_tag[i] = m_ptag; m_cnt[i] = int'(fill_lease); m_grant[i] = 0;
          for (int k = 0; k < 4; k++) m_mem[i][k] = fill_data[k*32 +: 32];
        end else if (i == ret) begin
          m_valid[i] = 0;
        end else if (grant_valid && i == gi && m_live(i, gt)) begin
          m_cnt[i] = int'(grant_lease); m_grant[i] = 1;
        end else if (m_valid[i] != 0 && m_cnt[i] != 0) begin
          m_cnt[i] = m_cnt[i] - 1;
        end
      end
      e_ready = !m_wait;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(rd_ready === e_ready, "R10", 64'(rd_ready), 64'(e_ready));
      chk(rd_resp_valid === e_rv, e_rv ? e_rtag : "R4", 64'(rd_resp_valid), 64'(e_rv));
      if (e_rv) chk(rd_resp_data === e_rd, e_rtag, 64'(rd_resp_data), 64'(e_rd));
      chk(fetch_valid === e_fv, e_fv ? e_ftag : "R2", 64'(fetch_valid), 64'(e_fv));
      if (e_fv) chk({fetch_line, fetch_lease} === {e_fl, e_fls}, e_ftag,
                    64'({fetch_line, fetch_lease}), 64'({e_fl, e_fls}));
      chk(inval_valid === e_iv, e_iv ? e_itag : "R6", 64'(inval_valid), 64'(e_iv));
      if (e_iv) chk(inval_line === e_il, e_itag, 64'(inval_line), 64'(e_il));
      chk(renew_req_valid === e_nv, "R8", 64'(renew_req_valid), 64'(e_nv));
      if (e_nv) chk(renew_req_line === e_nl, "R8", 64'(renew_req_line), 64'(e_nl));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", 64'(cyc), 64'd0);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  int salt = 16'h1000;

  function automatic logic [127:0] mkline(logic [13:0] line, int s);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = {line, 2'(k), 16'(s)};
    return v;
  endfunction

  task automatic rd(input logic [15:0] a, input logic [15:0] lease);
    rd_valid = 1; rd_addr = a; rd_lease = lease;
    for (int k = 0; k < 200 && !rd_ready; k++) @(negedge clk);
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic home_fill(input logic [15:0] lease, input int dly);
    logic [13:0] ln;
    for (int k = 0; k < 40 && !fetch_valid; k++) @(negedge clk);
    if (!fetch_valid) begin
      chk(0, "R2", 64'd0, 64'd1);
      return;
    end
    ln = fetch_line;
    repeat (dly) @(negedge clk);
    salt++;
    fill_valid = 1; fill_data = mkline(ln, salt); fill_lease = lease;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rd_ready === 1'b1, "R1", 64'(rd_ready), 64'd1);
    chk({rd_resp_valid, fetch_valid, inval_valid, renew_req_valid} === 4'b0, "R1",
        64'({rd_resp_valid, fetch_valid, inval_valid, renew_req_valid}), 64'd0);

    // R2/R3 miss and fill, then R4 hits on the same line
    rd(16'h0124, 16'd20); home_fill(16'd30, 2);
    rd(16'h0125, 16'd20); rd(16'h0127, 16'd20); idle(3);
    // R6 expiry, then miss again
    idle(40);
    rd(16'h0126, 16'd9); home_fill(16'd3, 1);
    // R5 back-to-back reads: three hits, then the expired cycle misses
    rd(16'h0124, 16'd1); rd(16'h0125, 16'd1); rd(16'h0126, 16'd1); rd(16'h0127, 16'd1);
    home_fill(16'd15, 0);
    idle(20);
    // R5 lifetime zero
    rd(16'h00CC, 16'd0); home_fill(16'd0, 1);
    rd(16'h00CD, 16'd4); home_fill(16'd6, 1);
    idle(12);
    // R6 two lines expiring together, lowest index first
    rd(16'h0044, 16'd12); home_fill(16'd12, 1);
    rd(16'h0088, 16'd8); home_fill(16'd8, 2);
    idle(25);
    // R7 eviction of a live line
    rd(16'h0054, 16'd50); home_fill(16'd50, 1);
    rd(16'h0094, 16'd50); home_fill(16'd50, 1);
    idle(2);
    // R8/R9 renewal and grants
    renew_valid = 1; renew_line = 14'h025; @(negedge clk);
    renew_line = 14'h037; @(negedge clk);
    renew_valid = 0;
    grant_valid = 1; grant_line = 14'h025; grant_lease = 16'd90; @(negedge clk);
    grant_line = 14'h037; grant_lease = 16'd5; @(negedge clk);
    grant_valid = 0;
    idle(110);
    // R10 a read held during a pending miss
    rd(16'h029C, 16'd40);
    fork
      rd(16'h029D, 16'd40);
      home_fill(16'd40, 4);
    join
    idle(3);
    // R3 fill with no miss waiting is ignored
    fill_valid = 1; fill_data = mkline(14'h0B8, 7); fill_lease = 16'd50;
    @(negedge clk);
    fill_valid = 0;
    idle(2);
    rd(16'h02E0, 16'd10);
    chk(fetch_valid === 1'b1, "R3", 64'(fetch_valid), 64'd1);
    home_fill(16'd10, 1);
    idle(60);
    finish_run();
  end
endmodule